// File: doc/BRIEF.md
# UART Receive FIFO Controller with Trigger and Timeout Interrupts

This block sits between a UART's receive shifter and the host. Each time the shifter finishes a character it presents a byte-valid strobe. The controller stores that byte in a small circular buffer, and the host drains the buffer through a read-request port. The shifter also reports every start-bit detection. A baud generator supplies one tick per bit period.

The controller raises two interrupts:
- **Level trigger:** pulses when the fill level climbs to a programmable threshold.
- **Receive timeout:** pulses when bytes sit in the buffer and no new character has begun within a programmable number of bit periods. This lets the host collect a tail of data smaller than the threshold.

A mode input selects a one-byte single-buffer mode or the full FIFO mode. The timeout works only in FIFO mode, only with its enable set, and only while reception is enabled.

Top module: `uart_rx_fifo_ctl`

## Requirements
- R1: After reset, fillCount is 0, trigIrq, timeoutIrq and overrun are 0, and rdData is 0.
- R2: Bytes are returned in write order. rdData and fillCount reflect a read in the cycle after the read request. Each accepted write raises fillCount by one.
- R3: Capacity is DEPTH (16) in FIFO mode and 1 in single mode. A byte presented at capacity is dropped, even if a read happens in the same cycle. A dropped byte sets overrun, which stays set until overrunClr is asserted.
- R4: A read request while the buffer is empty leaves rdData at its last value and fillCount at 0.
- R5: trigIrq is a one-cycle pulse, issued the cycle after a write that lifts fillCount from below the effective trigger to at or above it. The effective trigger is:
  - 1 in single mode;
  - trigLevel in FIFO mode;
  - 1 in FIFO mode when trigLevel is 0.
- R6: A start bit arms the timeout and zeroes its tick count. The tick count advances on each bitTick up to toWait. timeoutIrq pulses for one cycle in the cycle after the first cycle in which the count has reached toWait and fillCount is at least 1. The timeout is then disarmed and does not pulse again until another start bit.
- R7: Without a start bit since the timeout was last disarmed, timeoutIrq never pulses, whatever the fill level.
- R8: In single mode, or with toEnable at 0, timeoutIrq never pulses.
- R9: While rxEnable is 0:
  - byteValid and startDet are ignored;
  - the timeout is disarmed;
  - no timeout pulse occurs, either then or after re-enabling, until a fresh start bit.
- R10: A start bit in the same cycle as a pending expiry restarts the count and suppresses that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| rxEnable | input | 1 | Reception enable |
| fifoMode | input | 1 | 1 selects FIFO mode, 0 selects single-buffer mode |
| toEnable | input | 1 | Timeout counter enable |
| toWait | input | 5 | Timeout wait in bit periods |
| trigLevel | input | 4 | Fill-level trigger threshold |
| byteValid | input | 1 | Received byte strobe from the shifter |
| byteIn | input | 8 | Received byte |
| startDet | input | 1 | Start-bit detection strobe |
| bitTick | input | 1 | One pulse per bit period |
| rdReq | input | 1 | Host read request |
| overrunClr | input | 1 | Clears the overrun flag |
| rdData | output | 8 | Last byte read |
| fillCount | output | 5 | Bytes held |
| trigIrq | output | 1 | Level trigger interrupt pulse |
| timeoutIrq | output | 1 | Receive timeout interrupt pulse |
| overrun | output | 1 | Sticky overrun flag |

## Verification
A new start bit and a timeout expiry can land in the same cycle. The bench arms the timeout with one byte waiting, issues exactly toWait ticks, and then asserts startDet in the very cycle the expiry would be captured. It judges the result by requiring no pulse in that cycle, followed by exactly one pulse after a further toWait ticks. A second collision, a write and a read at full capacity in one cycle, is judged by the fill count, the overrun flag and the order of the data later read out.

// File: rtl/urxf_pkg.sv
package urxf_pkg;
  typedef struct packed {
    logic wrEn;
    logic rdEn;
  } fifoStrobes_t;
endpackage

// File: rtl/urxf_datapath.sv
module urxf_datapath
  import urxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int AW    = $clog2(DEPTH),
  localparam int CW    = AW + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strobes,
  input  logic [DATA_W-1:0] byteIn,
  output logic [DATA_W-1:0] rdData,
  output logic [CW-1:0]     fillCount
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0] wrPtr, rdPtr;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
  endfunction

  always_ff @(posedge clk) begin
    if (strobes.wrEn) mem[wrPtr] <= byteIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr     <= '0;
      rdPtr     <= '0;
      fillCount <= '0;
      rdData    <= '0;
    end else begin
      if (strobes.wrEn) wrPtr <= bump(wrPtr);
      if (strobes.rdEn) begin
        rdPtr  <= bump(rdPtr);
        rdData <= mem[rdPtr];
      end
      fillCount <= fillCount + CW'(strobes.wrEn) - CW'(strobes.rdEn);
    end
  end
endmodule

// File: rtl/urxf_control.sv
module urxf_control
  import urxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int WAIT_W = 5,
  parameter int TRIG_W = 4,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              fifoMode,
  input  logic              toEnable,
  input  logic [WAIT_W-1:0] toWait,
  input  logic [TRIG_W-1:0] trigLevel,
  input  logic              byteValid,
  input  logic              startDet,
  input  logic              bitTick,
  input  logic              rdReq,
  input  logic              overrunClr,
  input  logic [CW-1:0]     fillCount,
  output fifoStrobes_t      strobes,
  output logic              trigIrq,
  output logic              timeoutIrq,
  output logic              overrun
);
  logic [CW-1:0]     capacity, effTrig, nextCount;
  logic              full, wrAttempt, trigHit;
  logic              toActive, armed, expire;
  logic [WAIT_W-1:0] tickCnt;

  // Buffer admission
  always_comb begin
    capacity     = fifoMode ? CW'(DEPTH) : CW'(1);
    full         = fillCount >= capacity;
    wrAttempt    = rxEnable && byteValid;
    strobes.wrEn = wrAttempt && !full;
    strobes.rdEn = rdReq && (fillCount != '0);
    nextCount    = fillCount + CW'(strobes.wrEn) - CW'(strobes.rdEn);
  end

  // Level trigger: zero threshold behaves as one
  always_comb begin
    if (!fifoMode || trigLevel == '0) effTrig = CW'(1);
    else                              effTrig = CW'(trigLevel);
    trigHit = strobes.wrEn && (fillCount < effTrig) && (nextCount >= effTrig);
  end

  // Receive timeout
  always_comb begin
    toActive = rxEnable && fifoMode && toEnable;
    expire   = toActive && armed && !startDet &&
               (tickCnt >= toWait) && (fillCount != '0);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      armed   <= 1'b0;
      tickCnt <= '0;
    end else if (!toActive) begin
      armed   <= 1'b0;
      tickCnt <= '0;
    end else if (startDet) begin
      armed   <= 1'b1;
      tickCnt <= '0;
    end else if (expire) begin
      armed   <= 1'b0;
    end else if (armed && bitTick && tickCnt < toWait) begin
      tickCnt <= tickCnt + WAIT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigIrq    <= 1'b0;
      timeoutIrq <= 1'b0;
      overrun    <= 1'b0;
    end else begin
      trigIrq    <= trigHit;
      timeoutIrq <= expire;
      if (wrAttempt && full) overrun <= 1'b1;
      else if (overrunClr)   overrun <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_rx_fifo_ctl.sv
module uart_rx_fifo_ctl
  import urxf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  parameter int WAIT_W = 5,
  parameter int TRIG_W = 4,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEnable,
  input  logic              fifoMode,
  input  logic              toEnable,
  input  logic [WAIT_W-1:0] toWait,
  input  logic [TRIG_W-1:0] trigLevel,
  input  logic              byteValid,
  input  logic [DATA_W-1:0] byteIn,
  input  logic              startDet,
  input  logic              bitTick,
  input  logic              rdReq,
  input  logic              overrunClr,
  output logic [DATA_W-1:0] rdData,
  output logic [CW-1:0]     fillCount,
  output logic              trigIrq,
  output logic              timeoutIrq,
  output logic              overrun
);
  fifoStrobes_t strobes;

  urxf_control #(.DEPTH(DEPTH), .WAIT_W(WAIT_W), .TRIG_W(TRIG_W)) ctrl (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fifoMode(fifoMode),
    .toEnable(toEnable), .toWait(toWait), .trigLevel(trigLevel),
    .byteValid(byteValid), .startDet(startDet), .bitTick(bitTick),
    .rdReq(rdReq), .overrunClr(overrunClr), .fillCount(fillCount),
    .strobes(strobes), .trigIrq(trigIrq), .timeoutIrq(timeoutIrq),
    .overrun(overrun)
  );

  urxf_datapath #(.DEPTH(DEPTH), .DATA_W(DATA_W)) dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .byteIn(byteIn),
    .rdData(rdData), .fillCount(fillCount)
  );
endmodule

// File: rtl/urxf_checker.sv
module urxf_checker #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 8,
  localparam int CW    = $clog2(DEPTH) + 1
) (
  input logic              clk,
  input logic              rstN,
  input logic              rxEnable,
  input logic              fifoMode,
  input logic              toEnable,
  input logic              byteValid,
  input logic              startDet,
  input logic              rdReq,
  input logic              overrunClr,
  input logic [DATA_W-1:0] rdData,
  input logic [CW-1:0]     fillCount,
  input logic              trigIrq,
  input logic              timeoutIrq,
  input logic              overrun
);
  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rstN)
    fillCount <= CW'(DEPTH));

  assert_overrun_sticky_R3: assert property (@(posedge clk) disable iff (!rstN)
    overrun && !overrunClr |=> overrun);

  assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rstN)
    rdReq && fillCount == '0 && !byteValid |=> $stable(rdData) && fillCount == '0);

  assert_trig_pulse_R5: assert property (@(posedge clk) disable iff (!rstN)
    trigIrq |=> !trigIrq);

  assert_trig_has_data_R5: assert property (@(posedge clk) disable iff (!rstN)
    trigIrq |-> fillCount != '0);

  assert_timeout_pulse_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |=> !timeoutIrq);

  assert_timeout_needs_data_R6: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> $past(fillCount) != '0);

  // R8, R9, R10: a pulse implies the gating held and no start bit arrived.
  assert_timeout_gated_R8: assert property (@(posedge clk) disable iff (!rstN)
    timeoutIrq |-> $past(fifoMode && toEnable && rxEnable && !startDet));
endmodule

bind uart_rx_fifo_ctl urxf_checker #(.DEPTH(DEPTH), .DATA_W(DATA_W)) chk (
  .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fifoMode(fifoMode),
  .toEnable(toEnable), .byteValid(byteValid), .startDet(startDet),
  .rdReq(rdReq), .overrunClr(overrunClr), .rdData(rdData),
  .fillCount(fillCount), .trigIrq(trigIrq), .timeoutIrq(timeoutIrq),
  .overrun(overrun)
);

// File: tb/uart_rx_fifo_ctl_test.sv
`timescale 1ns/1ps
module uart_rx_fifo_ctl_test;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic rxEnable = 1'b1, fifoMode = 1'b1, toEnable = 1'b0;
  logic [4:0] toWait = '0;
  logic [3:0] trigLevel = '0;
  logic byteValid = 1'b0, startDet = 1'b0, bitTick = 1'b0;
  logic rdReq = 1'b0, overrunClr = 1'b0;
  logic [7:0] byteIn = '0;
  logic [7:0] rdData;
  logic [4:0] fillCount;
  logic trigIrq, timeoutIrq, overrun;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_rx_fifo_ctl uut (
    .clk(clk), .rstN(rstN), .rxEnable(rxEnable), .fifoMode(fifoMode),
    .toEnable(toEnable), .toWait(toWait), .trigLevel(trigLevel),
    .byteValid(byteValid), .byteIn(byteIn), .startDet(startDet),
    .bitTick(bitTick), .rdReq(rdReq), .overrunClr(overrunClr),
    .rdData(rdData), .fillCount(fillCount), .trigIrq(trigIrq),
    .timeoutIrq(timeoutIrq), .overrun(overrun)
  );

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wrByte(input logic [7:0] b);
    byteValid = 1'b1; byteIn = b;
    step();
    byteValid = 1'b0;
  endtask

  task automatic rdByte();
    rdReq = 1'b1;
    step();
    rdReq = 1'b0;
  endtask

  task automatic drain();
    while (fillCount != 0) rdByte();
  endtask

  task automatic ticks(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      bitTick = 1'b1;
      step();
      chk(req, timeoutIrq, 0);
    end
    bitTick = 1'b0;
  endtask

  function automatic logic [7:0] pat(input int t, input int i);
    return 8'(t * 17 + i * 3 + 5);
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    step(); step();
    rstN = 1'b1;
    step();
    // R1 reset state
    chk("R1 fillCount", fillCount, 0);
    chk("R1 trigIrq", trigIrq, 0);
    chk("R1 timeoutIrq", timeoutIrq, 0);
    chk("R1 overrun", overrun, 0);
    chk("R1 rdData", rdData, 0);

    // R4 read of empty buffer after reset
    rdByte();
    chk("R4 rdData", rdData, 0);
    chk("R4 fillCount", fillCount, 0);

    // R5 / R2 / R3 sweep over every trigger level
    for (int t = 0; t < 16; t++) begin
      int eff;
      eff = (t == 0) ? 1 : t;
      trigLevel = 4'(t);
      for (int i = 1; i <= 16; i++) begin
        wrByte(pat(t, i));
        chk("R5 trigIrq", trigIrq, (i == eff) ? 1 : 0);
        chk("R2 fillCount", fillCount, i);
      end
      wrByte(8'hEE);
      chk("R3 count at full", fillCount, 16);
      chk("R3 overrun set", overrun, 1);
      chk("R5 no trig when dropped", trigIrq, 0);
      step();
      chk("R3 overrun sticky", overrun, 1);
      overrunClr = 1'b1; step(); overrunClr = 1'b0;
      chk("R3 overrun cleared", overrun, 0);
      for (int i = 1; i <= 16; i++) begin
        rdByte();
        chk("R2 order", rdData, pat(t, i));
        chk("R2 count down", fillCount, 16 - i);
      end
      rdByte();
      chk("R4 hold data", rdData, pat(t, 16));
      chk("R4 stays empty", fillCount, 0);
    end

    // R3 write and read together at full: the write is dropped
    trigLevel = 4'd15;
    for (int i = 1; i <= 16; i++) wrByte(pat(20, i));
    byteValid = 1'b1; byteIn = 8'hAA; rdReq = 1'b1;
    step();
    byteValid = 1'b0; rdReq = 1'b0;
    chk("R3 full collision count", fillCount, 15);
    chk("R3 full collision overrun", overrun, 1);
    chk("R3 full collision data", rdData, pat(20, 1));
    for (int i = 2; i <= 16; i++) begin
      rdByte();
      chk("R3 no dropped byte stored", rdData, pat(20, i));
    end
    overrunClr = 1'b1; step(); overrunClr = 1'b0;

    // Single-buffer mode: R3, R5, R8
    fifoMode = 1'b0; toEnable = 1'b1; toWait = 5'd2; trigLevel = 4'd5;
    startDet = 1'b1; step(); startDet = 1'b0;
    wrByte(8'h31);
    chk("R5 single trig", trigIrq, 1);
    chk("R3 single count", fillCount, 1);
    wrByte(8'h32);
    chk("R3 single drop count", fillCount, 1);
    chk("R3 single overrun", overrun, 1);
    ticks(40, "R8 single no timeout");
    rdByte();
    chk("R3 single data", rdData, 8'h31);
    overrunClr = 1'b1; step(); overrunClr = 1'b0;
    fifoMode = 1'b1; trigLevel = 4'd8;

    // R6 timeout sweep over every wait value
    for (int w = 0; w < 32; w++) begin
      toWait = 5'(w);
      startDet = 1'b1; step(); startDet = 1'b0;
      wrByte(8'(w));
      chk("R6 quiet after write", timeoutIrq, 0);
      ticks(w, "R6 quiet while counting");
      step();
      chk("R6 pulse", timeoutIrq, 1);
      step();
      chk("R6 single cycle", timeoutIrq, 0);
      ticks(w + 3, "R6 not reissued");
      rdByte();
    end

    // R7 data but no start bit since disarm
    toEnable = 1'b0; step(); toEnable = 1'b1;
    toWait = 5'd3;
    wrByte(8'h55);
    ticks(40, "R7 no start no timeout");
    drain();

    // R8 timeout disabled
    toEnable = 1'b0;
    startDet = 1'b1; step(); startDet = 1'b0;
    wrByte(8'h56);
    ticks(40, "R8 disabled no timeout");
    drain();
    toEnable = 1'b1;

    // R9 reception disabled
    startDet = 1'b1; step(); startDet = 1'b0;
    wrByte(8'h57);
    rxEnable = 1'b0;
    wrByte(8'h58);
    chk("R9 byte ignored", fillCount, 1);
    startDet = 1'b1; step(); startDet = 1'b0;
    ticks(10, "R9 no timeout disabled");
    rxEnable = 1'b1;
    ticks(10, "R9 no timeout after re-enable");
    drain();

    // R10 start bit coincident with expiry
    toWait = 5'd4;
    startDet = 1'b1; step(); startDet = 1'b0;
    wrByte(8'h60);
    ticks(4, "R10 counting");
    startDet = 1'b1; step(); startDet = 1'b0;
    chk("R10 suppressed", timeoutIrq, 0);
    ticks(4, "R10 restarted count");
    step();
    chk("R10 later pulse", timeoutIrq, 1);
    drain();

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule